// File: doc/BRIEF.md
# ADC Result Buffer Controller

This block catches each finished analog conversion (a done strobe, a channel number and a result word) and decides where the result lands. It has a 26-entry result memory and picks the write location in one of three ways. It can fill the memory in order from location 0. It can put each result at the location equal to its channel number. Or it can alternate between the lower half (0..12) and the upper half (13..25), with a status flag that tells software which half is safe to read.

A fourth mode leaves the internal memory alone and sends each result to an external destination window. The window start and size are programmable, and the window is split into two halves that the same flag reports. A programmable sample count raises a one-cycle interrupt after every N accepted results. Software reads the memory through a synchronous read port and sets the modes through a 16-bit control word.

Top module: `adc_rbuf`

## Requirements
- R1: After reset the control word reads 0x0000, and `fill_flag_o`, `irq_o`, `chan_err_o` and `dma_we_o` are all 0.
- R2: The control word has the following fields:
  - bit 13 is destination-window mode.
  - bit 11 is channel-indexed mode.
  - bit 10 is scan enable. It is stored and read back, and it has no effect on writes.
  - bit 7 is the fill flag, which is read-only.
  - bits 6:2 hold N−1.
  - bit 1 is split mode.
  - all other bits read 0.

  When several modes are set, precedence is window > channel-indexed > split > sequential. Writing the word clears the write pointer, the sample count, the window offset, the fill flag and the error flag.
- R3: In sequential mode (bits 13, 11 and 1 all 0), the k-th accepted result since the last interrupt or control write goes to location k (counting from 0). From location 25 on, further results overwrite location 25.
- R4: In channel-indexed mode, a result on channel c (0 to 25) is written to location c.
- R5: In channel-indexed mode, a result with channel 26 or more is not written and not counted. It sets `chan_err_o`, which stays 1 until the next control write.
- R6: In split mode, results fill locations 0..12 while the flag is 0 and locations 13..25 while the flag is 1, starting at the base of the half. Results beyond the 13th in one half overwrite the last location of that half.
- R7: `irq_o` is a one-cycle pulse in the cycle after the N-th accepted result, and the count then restarts. In that same cycle the sequential pointer is back at 0, and in split mode the flag has toggled and the pointer is at the base of the new half.
- R8: In window mode, every strobe gives a one-cycle `dma_we_o` in the next cycle. It comes with `dma_addr_o` = start + offset and `dma_data_o` = the result. The offset steps by one and wraps to 0 at the window size. The internal memory is not written.
- R9: In window mode, `fill_flag_o` is 0 when the next window write falls in the lower half (offset < size/2) and 1 when it falls in the upper half.
- R10: A read returns memory data one cycle after `rd_en_i`. If the same location is written in the same cycle, the new data is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 16 | Control word write data |
| ctrl_rdata_o | output | 16 | Control word read-back |
| conv_done_i | input | 1 | Conversion finished strobe |
| conv_chan_i | input | 5 | Channel of the finished conversion |
| conv_data_i | input | 12 | Conversion result |
| dma_start_i | input | 16 | Destination window start address |
| dma_size_i | input | 16 | Destination window size (even, at least 2) |
| rd_en_i | input | 1 | Memory read enable |
| rd_addr_i | input | 5 | Memory read location |
| rd_data_o | output | 12 | Memory read data, one-cycle latency |
| dma_we_o | output | 1 | Destination window write strobe |
| dma_addr_o | output | 16 | Destination window write address |
| dma_data_o | output | 12 | Destination window write data |
| fill_flag_o | output | 1 | Half currently being filled |
| irq_o | output | 1 | Sample-count interrupt pulse |
| chan_err_o | output | 1 | Sticky out-of-range channel error |

## Verification
A wrong write pointer puts results in the wrong location, and the bench finds this on the next read-back of the swept locations, one cycle after the read request. A wrong sample count or flag state moves the interrupt, or the flag toggle, away from the cycle right after the N-th result, so it is visible at once at the ports. A wrong window offset shows up on `dma_addr_o` in the cycle after the strobe that uses it.

// File: rtl/adc_rbuf_pkg.sv
package adc_rbuf_pkg;
  localparam int CNT_W = 5;

  // control word bit positions
  localparam int B_DMA   = 13;
  localparam int B_CHAN  = 11;
  localparam int B_SCAN  = 10;
  localparam int B_FLAG  = 7;
  localparam int B_NLO   = 2;
  localparam int B_SPLIT = 1;

  typedef struct packed {
    logic             dma;
    logic             chan;
    logic             scan;
    logic             split;
    logic [CNT_W-1:0] n_m1;
  } mode_t;
endpackage

// File: rtl/adc_rbuf_cnt.sv
module adc_rbuf_cnt
  import adc_rbuf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             accept_i,
  input  logic [CNT_W-1:0] n_m1_i,
  output logic             hit_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;

  assign hit_o = accept_i && (cnt_q == n_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= hit_o;
      if (accept_i) cnt_q <= hit_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_rbuf_addr.sv
module adc_rbuf_addr
  import adc_rbuf_pkg::*;
#(
  parameter int DEPTH = 26,
  parameter int DW    = 12,
  parameter int DAW   = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  mode_t          mode_i,
  input  logic           conv_done_i,
  input  logic [AW-1:0]  conv_chan_i,
  input  logic [DW-1:0]  conv_data_i,
  input  logic [DAW-1:0] dma_start_i,
  input  logic [DAW-1:0] dma_size_i,
  input  logic           hit_i,
  output logic           accept_o,
  output logic           chan_bad_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic           flag_o,
  output logic           dma_we_o,
  output logic [DAW-1:0] dma_addr_o,
  output logic [DW-1:0]  dma_data_o
);
  localparam int HALF = DEPTH / 2;
  localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);
  localparam logic [AW-1:0] H_LAST = AW'(HALF - 1);
  localparam logic [AW-1:0] H_BASE = AW'(HALF);

  logic [AW-1:0]  ptr_q;
  logic [DAW-1:0] off_q;
  logic           flag_q;

  logic           chan_ok;
  logic [DAW:0]   off_inc;
  logic [DAW-1:0] off_nxt;
  logic           off_hi;

  assign chan_ok    = conv_chan_i <= LAST;
  assign chan_bad_o = conv_done_i && !mode_i.dma && mode_i.chan && !chan_ok;
  assign accept_o   = conv_done_i && !chan_bad_o;
  assign mem_we_o   = accept_o && !mode_i.dma;
  assign flag_o     = flag_q;

  always_comb begin
    if (mode_i.chan)       mem_addr_o = conv_chan_i;
    else if (mode_i.split) mem_addr_o = flag_q ? H_BASE + ptr_q : ptr_q;
    else                   mem_addr_o = ptr_q;
  end

  assign off_inc = {1'b0, off_q} + 1'b1;
  assign off_nxt = (off_inc >= {1'b0, dma_size_i}) ? '0 : off_inc[DAW-1:0];
  assign off_hi  = off_nxt >= (dma_size_i >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      off_q  <= '0;
      flag_q <= 1'b0;
    end else if (clr_i) begin
      ptr_q  <= '0;
      off_q  <= '0;
      flag_q <= 1'b0;
    end else if (accept_o) begin
      if (mode_i.dma) begin
        off_q  <= off_nxt;
        flag_q <= off_hi;
      end else if (!mode_i.chan) begin
        if (hit_i) begin
          ptr_q <= '0;
          if (mode_i.split) flag_q <= !flag_q;
        end else if (mode_i.split) begin
          if (ptr_q < H_LAST) ptr_q <= ptr_q + 1'b1;
        end else if (ptr_q < LAST) begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_we_o   <= 1'b0;
      dma_addr_o <= '0;
      dma_data_o <= '0;
    end else begin
      dma_we_o <= accept_o && mode_i.dma && !clr_i;
      if (accept_o && mode_i.dma) begin
        dma_addr_o <= dma_start_i + off_q;
        dma_data_o <= conv_data_i;
      end
    end
  end
endmodule

// File: rtl/adc_rbuf_mem.sv
module adc_rbuf_mem #(
  parameter int DEPTH = 26,
  parameter int DW    = 12,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && waddr_i <= LAST) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (re_i) begin
      if (we_i && waddr_i == raddr_i) rdata_o <= wdata_i;
      else if (raddr_i <= LAST)       rdata_o <= mem_q[raddr_i];
      else                            rdata_o <= '0;
    end
  end
endmodule

// File: rtl/adc_rbuf.sv
module adc_rbuf
  import adc_rbuf_pkg::*;
#(
  parameter int DEPTH = 26,
  parameter int DW    = 12,
  parameter int DAW   = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ctrl_we_i,
  input  logic [15:0]    ctrl_wdata_i,
  output logic [15:0]    ctrl_rdata_o,
  input  logic           conv_done_i,
  input  logic [AW-1:0]  conv_chan_i,
  input  logic [DW-1:0]  conv_data_i,
  input  logic [DAW-1:0] dma_start_i,
  input  logic [DAW-1:0] dma_size_i,
  input  logic           rd_en_i,
  input  logic [AW-1:0]  rd_addr_i,
  output logic [DW-1:0]  rd_data_o,
  output logic           dma_we_o,
  output logic [DAW-1:0] dma_addr_o,
  output logic [DW-1:0]  dma_data_o,
  output logic           fill_flag_o,
  output logic           irq_o,
  output logic           chan_err_o
);
  mode_t          mode_q;
  logic           accept, hit, chan_bad, mem_we;
  logic [AW-1:0]  mem_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= '0;
      chan_err_o <= 1'b0;
    end else if (ctrl_we_i) begin
      mode_q.dma   <= ctrl_wdata_i[B_DMA];
      mode_q.chan  <= ctrl_wdata_i[B_CHAN];
      mode_q.scan  <= ctrl_wdata_i[B_SCAN];
      mode_q.split <= ctrl_wdata_i[B_SPLIT];
      mode_q.n_m1  <= ctrl_wdata_i[B_NLO +: CNT_W];
      chan_err_o   <= 1'b0;
    end else if (chan_bad) begin
      chan_err_o <= 1'b1;
    end
  end

  always_comb begin
    ctrl_rdata_o                  = '0;
    ctrl_rdata_o[B_DMA]           = mode_q.dma;
    ctrl_rdata_o[B_CHAN]          = mode_q.chan;
    ctrl_rdata_o[B_SCAN]          = mode_q.scan;
    ctrl_rdata_o[B_FLAG]          = fill_flag_o;
    ctrl_rdata_o[B_NLO +: CNT_W]  = mode_q.n_m1;
    ctrl_rdata_o[B_SPLIT]         = mode_q.split;
  end

  adc_rbuf_addr #(.DEPTH(DEPTH), .DW(DW), .DAW(DAW)) u_addr (
    .clk_i, .rst_ni,
    .clr_i       (ctrl_we_i),
    .mode_i      (mode_q),
    .conv_done_i, .conv_chan_i, .conv_data_i,
    .dma_start_i, .dma_size_i,
    .hit_i       (hit),
    .accept_o    (accept),
    .chan_bad_o  (chan_bad),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .flag_o      (fill_flag_o),
    .dma_we_o, .dma_addr_o, .dma_data_o
  );

  adc_rbuf_cnt u_cnt (
    .clk_i, .rst_ni,
    .clr_i    (ctrl_we_i),
    .accept_i (accept),
    .n_m1_i   (mode_q.n_m1),
    .hit_o    (hit),
    .irq_o
  );

  adc_rbuf_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i, .rst_ni,
    .we_i    (mem_we),
    .waddr_i (mem_addr),
    .wdata_i (conv_data_i),
    .re_i    (rd_en_i),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/adc_rbuf_chk.sv
module adc_rbuf_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ctrl_we_i,
  input logic conv_done_i,
  input logic dma_en,
  input logic dma_we_o,
  input logic fill_flag_o,
  input logic irq_o,
  input logic chan_err_o
);
  // R7: a pulse needs an accepted result in the cycle before
  a_r7_irq_after_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(conv_done_i) && !$past(ctrl_we_i));

  // R5: error holds until a control write
  a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_err_o && !ctrl_we_i |=> chan_err_o);

  // R8: window strobe only after a strobe in window mode
  a_r8_dma_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_we_o |-> $past(conv_done_i) && $past(dma_en));

  // R6: outside window mode the flag moves only with an interrupt or a control write
  a_r6_flag_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fill_flag_o) && !$past(dma_en) && !$past(ctrl_we_i) |-> irq_o);

  // R2: a control write clears the error
  a_r2_ctrl_clears_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> !chan_err_o);
endmodule

bind adc_rbuf adc_rbuf_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (ctrl_we_i),
  .conv_done_i (conv_done_i),
  .dma_en      (mode_q.dma),
  .dma_we_o    (dma_we_o),
  .fill_flag_o (fill_flag_o),
  .irq_o       (irq_o),
  .chan_err_o  (chan_err_o)
);

// File: tb/adc_rbuf_bench.sv
`timescale 1ns/1ps
module adc_rbuf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [15:0] ctrl_rdata;
  logic        conv_done = 1'b0;
  logic [4:0]  conv_chan = '0;
  logic [11:0] conv_data = '0;
  logic [15:0] dma_start = 16'd100;
  logic [15:0] dma_size = 16'd8;
  logic        rd_en = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [11:0] rd_data;
  logic        dma_we;
  logic [15:0] dma_addr;
  logic [11:0] dma_data;
  logic        fill_flag, irq, chan_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  adc_rbuf u_adc_rbuf (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata),
    .conv_done_i(conv_done), .conv_chan_i(conv_chan), .conv_data_i(conv_data),
    .dma_start_i(dma_start), .dma_size_i(dma_size),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .dma_we_o(dma_we), .dma_addr_o(dma_addr), .dma_data_o(dma_data),
    .fill_flag_o(fill_flag), .irq_o(irq), .chan_err_o(chan_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // all drive/sample on negedge
  task automatic ctrl_wr(input logic [15:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic conv(input int ch, input int d);
    conv_done = 1'b1; conv_chan = 5'(ch); conv_data = 12'(d);
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_en = 1'b1; rd_addr = 5'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rd_data);
  endtask

  function automatic logic [15:0] cw(input bit dma, input bit chn, input bit split, input int n);
    cw = 16'(((n - 1) & 31) << 2);
    cw[13] = dma; cw[11] = chn; cw[1] = split;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int irq_seen;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "ctrl", int'(ctrl_rdata), 0);
    chk("R1", "flag", int'(fill_flag), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "err", int'(chan_err), 0);
    chk("R1", "dma_we", int'(dma_we), 0);

    // R2 layout and reserved bits
    ctrl_wr(16'hFFFF);
    chk("R2", "ctrl readback", int'(ctrl_rdata), 'h2C7E);

    // R3 sequential, N=4, scan bit set has no effect (R2)
    ctrl_wr(cw(0, 0, 0, 4) | 16'h0400);
    for (int i = 0; i < 4; i++) begin
      conv(7, 'h300 + i);
      chk("R7", $sformatf("seq irq after %0d", i + 1), int'(irq), (i == 3) ? 1 : 0);
    end
    @(negedge clk);
    chk("R7", "irq one cycle", int'(irq), 0);
    for (int i = 0; i < 4; i++) begin
      rd(i, v);
      chk("R3", $sformatf("seq loc %0d", i), v, 'h300 + i);
    end
    conv(7, 'h3AA);
    rd(0, v);
    chk("R7", "seq pointer back to 0", v, 'h3AA);
    chk("R2", "scan bit no flag effect", int'(fill_flag), 0);

    // R3 hold at last location, N=32
    ctrl_wr(cw(0, 0, 0, 32));
    for (int i = 0; i < 30; i++) conv(0, 'h500 + i);
    rd(24, v); chk("R3", "seq loc 24", v, 'h500 + 24);
    rd(25, v); chk("R3", "seq hold at 25", v, 'h500 + 29);

    // R6/R7 split, N=13
    ctrl_wr(cw(0, 0, 1, 13));
    for (int h = 0; h < 2; h++) begin
      for (int i = 0; i < 13; i++) begin
        chk("R6", $sformatf("split flag half%0d s%0d", h, i), int'(fill_flag), h);
        conv(0, 'h100 + h * 13 + i);
      end
      chk("R7", $sformatf("split irq half%0d", h), int'(irq), 1);
      chk("R7", $sformatf("split flag toggled half%0d", h), int'(fill_flag), 1 - h);
    end
    for (int a = 0; a < 26; a++) begin
      rd(a, v);
      chk("R6", $sformatf("split loc %0d", a), v, 'h100 + a);
    end

    // R6 overflow within half, N=16
    ctrl_wr(cw(0, 0, 1, 16));
    for (int i = 0; i < 16; i++) conv(0, 'h600 + i);
    chk("R7", "split N=16 irq", int'(irq), 1);
    chk("R6", "split N=16 flag", int'(fill_flag), 1);
    rd(11, v); chk("R6", "split loc 11", v, 'h600 + 11);
    rd(12, v); chk("R6", "split hold at 12", v, 'h600 + 15);
    rd(13, v); chk("R6", "upper untouched", v, 'h100 + 13);
    conv(0, 'h6EE);
    rd(13, v); chk("R6", "upper base after toggle", v, 'h6EE);

    // R4 channel-indexed, every valid channel
    ctrl_wr(cw(0, 1, 0, 32));
    for (int c = 25; c >= 0; c--) conv(c, 'h800 + c * 3);
    for (int c = 0; c < 26; c++) begin
      rd(c, v);
      chk("R4", $sformatf("chan loc %0d", c), v, 'h800 + c * 3);
    end

    // R5 out-of-range channels: no write, no count, sticky error
    ctrl_wr(cw(0, 1, 0, 2));
    conv(3, 'h0A1);
    chk("R5", "err clear before", int'(chan_err), 0);
    irq_seen = 0;
    for (int c = 26; c < 32; c++) begin
      conv(c, 'hFFF);
      irq_seen |= int'(irq);
    end
    chk("R5", "bad chan not counted", irq_seen, 0);
    chk("R5", "err set", int'(chan_err), 1);
    conv(4, 'h0A2);
    chk("R5", "count resumes, irq", int'(irq), 1);
    chk("R5", "err sticky", int'(chan_err), 1);
    for (int c = 0; c < 26; c++) begin
      rd(c, v);
      chk("R5", $sformatf("no stray write loc %0d", c), v,
          (c == 3) ? 'h0A1 : (c == 4) ? 'h0A2 : 'h800 + c * 3);
    end
    ctrl_wr(cw(0, 1, 0, 2));
    chk("R2", "ctrl write clears err", int'(chan_err), 0);

    // R10 same-cycle write bypass
    conv_done = 1'b1; conv_chan = 5'd9; conv_data = 12'hBEE;
    rd_en = 1'b1; rd_addr = 5'd9;
    @(negedge clk);
    conv_done = 1'b0; rd_en = 1'b0;
    chk("R10", "bypass data", int'(rd_data), 'hBEE);
    rd(10, v);
    chk("R10", "latency read", v, 'h800 + 30);

    // R8/R9 window mode, start 100 size 8, N=4; window has priority over chan (R2)
    ctrl_wr(cw(1, 1, 1, 4));
    for (int i = 0; i < 18; i++) begin
      conv(i % 32, 'h900 + i);
      chk("R8", $sformatf("dma_we s%0d", i), int'(dma_we), 1);
      chk("R8", $sformatf("dma_addr s%0d", i), int'(dma_addr), 100 + (i % 8));
      chk("R8", $sformatf("dma_data s%0d", i), int'(dma_data), 'h900 + i);
      chk("R9", $sformatf("dma flag s%0d", i), int'(fill_flag), (((i + 1) % 8) >= 4) ? 1 : 0);
      chk("R7", $sformatf("dma irq s%0d", i), int'(irq), ((i + 1) % 4 == 0) ? 1 : 0);
    end
    @(negedge clk);
    chk("R8", "dma_we one cycle", int'(dma_we), 0);
    chk("R5", "window mode no err", int'(chan_err), 0);
    rd(9, v);
    chk("R8", "memory not written", v, 'hBEE);

    // R7 N=1: irq on every result
    ctrl_wr(cw(0, 0, 0, 1));
    for (int i = 0; i < 3; i++) begin
      conv(0, 'h010 + i);
      chk("R7", $sformatf("N=1 irq %0d", i), int'(irq), 1);
    end
    rd(0, v);
    chk("R7", "N=1 pointer stays at 0", v, 'h012);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule